// File: doc/BRIEF.md
# Fuse Array Region Access Filter

This block stands between a word-addressed request port and a one-time-programmable fuse array of 800 words of 32 bits. Each request carries a byte address, a byte length, a direction and write data. The block turns the byte address into a word index and classifies that index against a parameter table of up to four regions. A region is either a hole, where no fuses exist, or an ECC region, where a word may be programmed only once.

Reads return one response beat per covered word. Hole words read as zero and the array is not touched for them. Writes must cover exactly one aligned word. A write to an ECC word first reads that word and is refused if any bit is already set. Only one request is handled at a time: `req_ready` is low from the cycle after acceptance until the last response beat, so a multi-word read keeps sole use of the array for its whole burst.

The controller is a state machine with these states: `S_IDLE` (ready, latches a request), `S_DECODE` (classifies the latched request), `S_RD_WORD` (issues an array read or answers a hole word), `S_RD_WAIT` (returns array data), `S_ECC_READ` (reads the target ECC word), `S_ECC_WAIT` (inspects it) and `S_PROGRAM` (writes the array). Transitions: `S_IDLE`→`S_DECODE` on `req_valid`; `S_DECODE`→`S_IDLE` on rejection, →`S_RD_WORD` for a legal read, →`S_PROGRAM` for a legal write outside ECC regions, →`S_ECC_READ` for a legal ECC write; `S_RD_WORD`→`S_RD_WAIT` on a non-hole word, or on a hole word →`S_RD_WORD` (more words) or `S_IDLE` (last word); `S_RD_WAIT`→`S_RD_WORD` (more words) or `S_IDLE` (last); `S_ECC_READ`→`S_ECC_WAIT`; `S_ECC_WAIT`→`S_IDLE` if the word is non-zero, else →`S_PROGRAM`; `S_PROGRAM`→`S_IDLE`.

Top module: `otp_guard`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and neither `arr_rd_en` nor `arr_wr_en` is asserted.
- R2: A read starting at byte address A with length L>0 returns ceil((A mod 4 + L)/4) beats for consecutive word indices from A/4, each with status OK and the full 32-bit array word; only the final beat has `rsp_last`=1.
- R3: A word with index 0x110 to 0x21F (hole) reads as zero and causes no array read.
- R4: A write whose length is not 4 bytes, or whose address has bits [1:0] non-zero, gets one INVALID beat and no array access.
- R5: A write to a hole word gets one INVALID beat and no array access.
- R6: A write to an ECC word (index 0x10 to 0x10F or 0x220 to 0x31F) whose stored value is non-zero performs one array read, no array write, and gets one IO_ERROR beat.
- R7: A legal write to an ECC word holding zero performs one read then one write; a legal write outside ECC regions performs one write and no read; both answer one OK beat.
- R8: A write to index 800 or above, a read whose last covered word is 800 or above, and a read of length 0 each get one INVALID beat and no array access.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle in which the last beat is shown; array read and write are never asserted together.
- R10: `rsp_status` encodes OK=0, INVALID=1, IO_ERROR=2; a non-OK beat carries `rsp_last`=1 and zero data, and write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = program, 0 = read |
| req_addr | input | 12 | Byte address |
| req_len | input | 8 | Byte length |
| req_wdata | input | 32 | Program data |
| rsp_valid | output | 1 | Response beat present (one cycle) |
| rsp_status | output | 2 | OK=0, INVALID=1, IO_ERROR=2 |
| rsp_data | output | 32 | Read data of the beat |
| rsp_last | output | 1 | Final beat of the request |
| arr_rd_en | output | 1 | Array read strobe, data due next cycle |
| arr_wr_en | output | 1 | Array program strobe |
| arr_idx | output | 10 | Array word index |
| arr_wdata | output | 32 | Array program data |
| arr_rdata | input | 32 | Array read data, one cycle after the strobe |

## Verification
Reads are tried as single aligned words, as unaligned bursts that straddle the ECC-to-hole boundary and as pure hole reads over fuses the bench has preset to non-zero, which separates correct zero-fill from a leaked array read. Writes are tried with bad lengths, bad alignment, hole targets and out-of-range indices, which separate each rejection path by the array access count that must stay zero. ECC writes go to blank and to already-set words, and the same word is written twice, which distinguishes the read-before-program guard from a plain write path; repeated plain writes show that non-ECC words bypass that guard.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_INVALID  = 2'd1,
        ST_IO_ERROR = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        V_REJECT,
        V_READ,
        V_WR_PLAIN,
        V_WR_ECC
    } verdict_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_RD_WORD,
        S_RD_WAIT,
        S_ECC_READ,
        S_ECC_WAIT,
        S_PROGRAM
    } state_e;

    // Flag field of a region entry: bit 0 marks ECC, bit 1 marks a hole.
    localparam int FLAG_ECC_BIT  = 0;
    localparam int FLAG_HOLE_BIT = 1;

endpackage

// File: rtl/otp_region_lookup.sv
module otp_region_lookup #(
    parameter int IDX_W = 10,
    parameter int NREG  = 3,
    parameter logic [NREG-1:0][IDX_W-1:0] REG_START = '0,
    parameter logic [NREG-1:0][IDX_W-1:0] REG_END   = '0,
    parameter logic [NREG-1:0][1:0]       REG_FLAG  = '0
) (
    input  logic [IDX_W-1:0] idx,
    output logic             in_hole,
    output logic             in_ecc
);
    import otp_guard_pkg::*;

    logic [NREG-1:0] hit;
    logic [NREG-1:0] hole_hit;
    logic [NREG-1:0] ecc_hit;

    for (genvar e = 0; e < NREG; e++) begin : g_entry
        assign hit[e]      = (idx >= REG_START[e]) && (idx <= REG_END[e]);
        assign hole_hit[e] = hit[e] && REG_FLAG[e][FLAG_HOLE_BIT];
        assign ecc_hit[e]  = hit[e] && REG_FLAG[e][FLAG_ECC_BIT];
    end

    assign in_hole = |hole_hit;
    // A hole overrides an overlapping ECC entry.
    assign in_ecc  = (|ecc_hit) && !in_hole;

endmodule

// File: rtl/otp_req_classify.sv
module otp_req_classify #(
    parameter int WORDS  = 800,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 8
) (
    input  logic                    is_write,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LEN_W-1:0]        len,
    input  logic                    first_hole,
    input  logic                    first_ecc,
    output otp_guard_pkg::verdict_e verdict,
    output logic [LEN_W-1:0]        burst_words
);
    import otp_guard_pkg::*;

    localparam int IDX_W = ADDR_W - 2;
    localparam int SUM_W = LEN_W + 2;
    localparam int EXT_W = ((IDX_W > LEN_W) ? IDX_W : LEN_W) + 1;

    logic [IDX_W-1:0] first_idx;
    logic [SUM_W-1:0] span;
    logic [EXT_W-1:0] last_ext;
    logic             first_out;
    logic             last_out;
    logic             aligned_word;

    assign first_idx    = addr[ADDR_W-1:2];
    assign span         = SUM_W'(addr[1:0]) + SUM_W'(len) + SUM_W'(3);
    assign burst_words  = span[SUM_W-1:2];
    assign last_ext     = EXT_W'(first_idx) + EXT_W'(burst_words) - EXT_W'(1);
    assign first_out    = EXT_W'(first_idx) >= EXT_W'(WORDS);
    assign last_out     = last_ext >= EXT_W'(WORDS);
    assign aligned_word = (len == LEN_W'(4)) && (addr[1:0] == 2'b00);

    always_comb begin
        verdict = V_REJECT;
        if (is_write) begin
            if (aligned_word && !first_out && !first_hole) begin
                verdict = first_ecc ? V_WR_ECC : V_WR_PLAIN;
            end
        end else begin
            if ((len != '0) && !last_out) begin
                verdict = V_READ;
            end
        end
    end

endmodule

// File: rtl/otp_guard.sv
module otp_guard #(
    parameter int WORDS  = 800,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 8,
    parameter int NREG   = 3,
    parameter logic [NREG-1:0][ADDR_W-3:0] REG_START = {10'h220, 10'h110, 10'h010},
    parameter logic [NREG-1:0][ADDR_W-3:0] REG_END   = {10'h31F, 10'h21F, 10'h10F},
    parameter logic [NREG-1:0][1:0]        REG_FLAG  = {2'b01, 2'b10, 2'b01}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last,
    output logic              arr_rd_en,
    output logic              arr_wr_en,
    output logic [ADDR_W-3:0] arr_idx,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata
);
    import otp_guard_pkg::*;

    localparam int IDX_W = ADDR_W - 2;
    localparam int CNT_W = LEN_W;

    state_e            state;
    state_e            state_nx;
    logic              lat_write;
    logic [ADDR_W-1:0] lat_addr;
    logic [LEN_W-1:0]  lat_len;
    logic [DATA_W-1:0] lat_wdata;
    logic [IDX_W-1:0]  cur_idx;
    logic [CNT_W-1:0]  words_left;
    logic              cur_hole;
    logic              cur_ecc;
    verdict_e          verdict;
    logic [CNT_W-1:0]  burst_words;
    logic              final_word;

    otp_region_lookup #(
        .IDX_W    (IDX_W),
        .NREG     (NREG),
        .REG_START(REG_START),
        .REG_END  (REG_END),
        .REG_FLAG (REG_FLAG)
    ) u_lookup (
        .idx    (cur_idx),
        .in_hole(cur_hole),
        .in_ecc (cur_ecc)
    );

    otp_req_classify #(
        .WORDS (WORDS),
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_classify (
        .is_write   (lat_write),
        .addr       (lat_addr),
        .len        (lat_len),
        .first_hole (cur_hole),
        .first_ecc  (cur_ecc),
        .verdict    (verdict),
        .burst_words(burst_words)
    );

    assign final_word = (words_left == CNT_W'(1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = S_DECODE;
            S_DECODE: begin
                unique case (verdict)
                    V_REJECT:   state_nx = S_IDLE;
                    V_READ:     state_nx = S_RD_WORD;
                    V_WR_PLAIN: state_nx = S_PROGRAM;
                    V_WR_ECC:   state_nx = S_ECC_READ;
                    default:    state_nx = S_IDLE;
                endcase
            end
            S_RD_WORD: begin
                if (!cur_hole)       state_nx = S_RD_WAIT;
                else if (final_word) state_nx = S_IDLE;
                else                 state_nx = S_RD_WORD;
            end
            S_RD_WAIT:  state_nx = final_word ? S_IDLE : S_RD_WORD;
            S_ECC_READ: state_nx = S_ECC_WAIT;
            S_ECC_WAIT: state_nx = (arr_rdata != '0) ? S_IDLE : S_PROGRAM;
            S_PROGRAM:  state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Registered outputs and request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_write  <= 1'b0;
            lat_addr   <= '0;
            lat_len    <= '0;
            lat_wdata  <= '0;
            cur_idx    <= '0;
            words_left <= '0;
            rsp_valid  <= 1'b0;
            rsp_status <= ST_OK;
            rsp_data   <= '0;
            rsp_last   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        lat_write <= req_write;
                        lat_addr  <= req_addr;
                        lat_len   <= req_len;
                        lat_wdata <= req_wdata;
                        cur_idx   <= req_addr[ADDR_W-1:2];
                    end
                end
                S_DECODE: begin
                    words_left <= burst_words;
                    if (verdict == V_REJECT) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_INVALID;
                        rsp_data   <= '0;
                        rsp_last   <= 1'b1;
                    end
                end
                S_RD_WORD: begin
                    if (cur_hole) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_OK;
                        rsp_data   <= '0;
                        rsp_last   <= final_word;
                        cur_idx    <= cur_idx + IDX_W'(1);
                        words_left <= words_left - CNT_W'(1);
                    end
                end
                S_RD_WAIT: begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= ST_OK;
                    rsp_data   <= arr_rdata;
                    rsp_last   <= final_word;
                    cur_idx    <= cur_idx + IDX_W'(1);
                    words_left <= words_left - CNT_W'(1);
                end
                S_ECC_READ: begin
                end
                S_ECC_WAIT: begin
                    if (arr_rdata != '0) begin
                        rsp_valid  <= 1'b1;
                        rsp_status <= ST_IO_ERROR;
                        rsp_data   <= '0;
                        rsp_last   <= 1'b1;
                    end
                end
                S_PROGRAM: begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= ST_OK;
                    rsp_data   <= '0;
                    rsp_last   <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // Array strobes and handshake
    assign req_ready = (state == S_IDLE);
    assign arr_rd_en = ((state == S_RD_WORD) && !cur_hole) || (state == S_ECC_READ);
    assign arr_wr_en = (state == S_PROGRAM);
    assign arr_idx   = cur_idx;
    assign arr_wdata = lat_wdata;

endmodule

// File: rtl/otp_guard_checker.sv
module otp_guard_checker #(
    parameter int WORDS  = 800,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int NREG   = 3,
    parameter logic [NREG-1:0][ADDR_W-3:0] REG_START = '0,
    parameter logic [NREG-1:0][ADDR_W-3:0] REG_END   = '0,
    parameter logic [NREG-1:0][1:0]        REG_FLAG  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_last,
    input logic              arr_rd_en,
    input logic              arr_wr_en,
    input logic [ADDR_W-3:0] arr_idx
);
    function automatic logic flag_at(input logic [ADDR_W-3:0] i, input int bitpos);
        logic r;
        r = 1'b0;
        for (int e = 0; e < NREG; e++) begin
            if (i >= REG_START[e] && i <= REG_END[e] && REG_FLAG[e][bitpos]) r = 1'b1;
        end
        return r;
    endfunction

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_rd_en && arr_wr_en));

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_last_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |-> req_ready);

    p_err_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_last && rsp_data == '0));

    p_status_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));

    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_wr_en) |-> (int'(arr_idx) < WORDS));

    p_hole_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_wr_en) |-> !flag_at(arr_idx, 1));

    p_ecc_checked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && flag_at(arr_idx, 0)) |->
            ($past(arr_rd_en, 2) && $past(arr_idx, 2) == arr_idx));

endmodule

bind otp_guard otp_guard_checker #(
    .WORDS    (WORDS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NREG     (NREG),
    .REG_START(REG_START),
    .REG_END  (REG_END),
    .REG_FLAG (REG_FLAG)
) u_otp_guard_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_status(rsp_status),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last),
    .arr_rd_en (arr_rd_en),
    .arr_wr_en (arr_wr_en),
    .arr_idx   (arr_idx)
);

// File: tb/test_otp_guard.sv
`timescale 1ns/1ps
module test_otp_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_data;
    logic        rsp_last;
    logic        arr_rd_en;
    logic        arr_wr_en;
    logic [9:0]  arr_idx;
    logic [31:0] arr_wdata;
    logic [31:0] arr_rdata = '0;

    always #2.5 clk = ~clk;

    otp_guard i_otp_guard (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
        .rsp_last(rsp_last), .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en),
        .arr_idx(arr_idx), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    localparam int OK = 0, INV = 1, IOE = 2;

    logic [31:0] fuse [0:799];
    int n_checks = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [34:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    // Fuse array model: one-cycle read latency, programming sets bits.
    always @(posedge clk) begin
        if (arr_rd_en) begin
            rd_cnt++;
            arr_rdata <= (int'(arr_idx) < 800) ? fuse[arr_idx] : 32'hX;
        end
        if (arr_wr_en) begin
            wr_cnt++;
            if (int'(arr_idx) < 800) fuse[arr_idx] = fuse[arr_idx] | arr_wdata;
        end
    end

    function automatic bit is_hole(int i);
        return i >= 'h110 && i <= 'h21F;
    endfunction
    function automatic bit is_ecc(int i);
        return (i >= 'h10 && i <= 'h10F) || (i >= 'h220 && i <= 'h31F);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Response monitor: every clock, compare a shown beat with the model queue.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected beat", {rsp_status, rsp_last, rsp_data}, 0);
            end else begin
                logic [34:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({rsp_status, rsp_last, rsp_data} == e, t, "beat {status,last,data}",
                      {rsp_status, rsp_last, rsp_data}, e);
            end
        end
    end

    task automatic push(int st, bit last, logic [31:0] d, string tag);
        exp_q.push_back({st[1:0], last, d});
        tag_q.push_back(tag);
    endtask

    task automatic send(bit wr, int addr, int len, logic [31:0] wd, string tag, int erd, int ewr);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr[11:0];
        req_len   = len[7:0];
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check(rd_cnt == erd, tag, "array reads", rd_cnt, erd);
        check(wr_cnt == ewr, tag, "array writes", wr_cnt, ewr);
    endtask

    // Reference: read of len bytes from addr
    task automatic rd(int addr, int len, string tag);
        int n, first, erd;
        n = ((addr % 4) + len + 3) / 4;
        first = addr / 4;
        erd = 0;
        if (len == 0 || first + n - 1 >= 800) begin
            push(INV, 1'b1, 0, tag);
        end else begin
            for (int k = 0; k < n; k++) begin
                int i;
                i = first + k;
                if (is_hole(i)) push(OK, k == n - 1, 0, tag);
                else begin
                    push(OK, k == n - 1, fuse[i], tag);
                    erd++;
                end
            end
        end
        send(1'b0, addr, len, 0, tag, erd, 0);
    endtask

    // Reference: write of len bytes at addr
    task automatic wr(int addr, int len, logic [31:0] d, string tag);
        int i;
        i = addr / 4;
        if (len != 4 || (addr % 4) != 0 || i >= 800 || is_hole(i)) begin
            push(INV, 1'b1, 0, tag);
            send(1'b1, addr, len, d, tag, 0, 0);
        end else if (is_ecc(i)) begin
            if (fuse[i] != 0) begin
                push(IOE, 1'b1, 0, tag);
                send(1'b1, addr, len, d, tag, 1, 0);
            end else begin
                push(OK, 1'b1, 0, tag);
                send(1'b1, addr, len, d, tag, 1, 1);
            end
        end else begin
            push(OK, 1'b1, 0, tag);
            send(1'b1, addr, len, d, tag, 0, 1);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 800; i++) fuse[i] = 32'h0;
        fuse[5]     = 32'h0000_1234;
        fuse['h20]  = 32'h0000_00A5;
        fuse['h10E] = 32'h1111_0000;
        fuse['h10F] = 32'h2222_0000;
        fuse['h111] = 32'hBEEF_0000;
        fuse['h150] = 32'hDEAD_0000;
        fuse[797]   = 32'h7777_0001;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        check(!arr_rd_en && !arr_wr_en, "R1", "array strobes in reset", {arr_rd_en, arr_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "idle after reset", {req_ready, rsp_valid}, 2);

        rd(5 * 4, 4, "R2");                 // single aligned word
        rd('h10E * 4 + 2, 12, "R2");        // unaligned burst across ECC->hole
        rd(797 * 4, 12, "R2");              // burst ending at the last word
        rd('h150 * 4, 4, "R3");             // hole word with preset fuses
        rd('h21E * 4, 16, "R3");            // hole exit into ECC region
        wr(2 * 4, 3, 32'h1, "R4");          // bad length
        wr(2 * 4 + 1, 4, 32'h1, "R4");      // misaligned
        wr('h150 * 4, 4, 32'h1, "R5");      // hole target
        rd('h150 * 4, 4, "R5");
        wr('h20 * 4, 4, 32'h5A, "R6");      // ECC already set
        rd('h20 * 4, 4, "R6");
        wr('h30 * 4, 4, 32'hCAFE, "R7");    // ECC blank
        rd('h30 * 4, 4, "R7");
        wr('h30 * 4, 4, 32'h1, "R6");       // second program refused
        wr('h31F * 4, 4, 32'h9, "R7");      // top ECC word
        wr(2 * 4, 4, 32'h11, "R7");         // plain word
        wr(2 * 4, 4, 32'h22, "R7");         // plain again, no guard
        rd(2 * 4, 4, "R7");
        wr(800 * 4, 4, 32'h1, "R8");        // index out of range
        rd(798 * 4, 12, "R8");              // burst past the end
        rd(8, 0, "R8");                     // zero length
        rd(0, 255, "R10");                  // long burst, status codes OK
        done = 1'b1;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9", "pending beats", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule